// File: doc/BRIEF.md
# Compare-and-Branch Condition Unit

This block decides, within a single cycle, whether a compare-and-jump instruction is taken and what the instruction pointer becomes next. It receives the 32-bit instruction word, the values read for the two source register fields, the current instruction pointer and the jump target. It selects the second comparand from one of two sources. In the register form this is the value named by the second register field. In the immediate form it is the instruction's low 16 bits, sign-extended. It then evaluates the condition selected by a 4-bit code.

The unit is purely combinational and sits between register read and the fetch address mux. A register index of zero reads as zero, whatever value the register file presents. Condition codes outside the defined set are flagged as invalid and never cause a jump. Instruction words whose opcode is neither compare-and-jump form leave the pointer advancing by one.

Top module: `brcond_unit`

## Requirements
- R1: The opcode sits in bits 31:24, the condition code in bits 23:20 and the first register index in bits 19:16. Opcode OPC_REG (default 8'h40) selects the register form, whose second register index is in bits 15:12.
- R2: A register index of 0, in either the first or the second register field, reads as zero regardless of the supplied register value.
- R3: Condition code 4'h0 is always taken.
- R4: Code 4'h1 is taken when the two comparands differ. Code 4'h2 is taken when they are equal.
- R5: Code 4'h3 is taken when the first comparand is strictly greater as an unsigned number. Code 4'h4 is taken when it is greater or equal as an unsigned number.
- R6: Code 4'hC is taken when the first comparand is strictly greater as a two's-complement number. Code 4'hD is taken when it is greater or equal as a two's-complement number.
- R7: For a compare-and-jump opcode, codes 4'h5 to 4'hB, 4'hE and 4'hF drive `cond_invalid` high and `taken` low.
- R8: `next_ip` equals `target` when taken and `ip + 1` otherwise, wrapping modulo 2^32.
- R9: Any opcode other than OPC_REG and OPC_IMM gives `taken` low, `cond_invalid` low and `next_ip = ip + 1`.
- R10: Opcode OPC_IMM (default 8'h41) selects the immediate form. Bits 15:0 are sign-extended to 32 bits and used as the second comparand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr | input | 32 | Instruction word under evaluation |
| ip | input | 32 | Current instruction pointer |
| rs1_val | input | 32 | Value read for the first register field |
| rs2_val | input | 32 | Value read for the second register field |
| target | input | 32 | Jump destination used when taken |
| taken | output | 1 | Jump condition holds |
| cond_invalid | output | 1 | Undefined condition code on a compare-and-jump opcode |
| next_ip | output | 32 | Pointer for the next fetch |

## Verification
The bench goes after operands that straddle the sign boundary, such as 32'h8000_0000 against 1 and all-ones against zero. A design that swapped signed and unsigned ordering would give the opposite answer on exactly these pairs. Immediates with bit 15 set check sign extension: a zero-extending design fails equality against negative register values. Equal operands under the strict and non-strict ordering codes expose an off-by-one in the comparator. Register index zero with a non-zero supplied value exposes a missing zero override. An instruction pointer of all ones checks that the fall-through wraps to zero. Undefined codes and foreign opcodes must leave the pointer advancing by one.

// File: rtl/brcond_pkg.sv
package brcond_pkg;

    localparam int INSTR_W = 32;
    localparam int OPC_W   = 8;
    localparam int COND_W  = 4;
    localparam int IDX_W   = 4;
    localparam int IMM_W   = 16;

    localparam int OPC_LSB  = INSTR_W - OPC_W;
    localparam int COND_LSB = OPC_LSB - COND_W;
    localparam int RS1_LSB  = COND_LSB - IDX_W;
    localparam int RS2_LSB  = RS1_LSB - IDX_W;

    typedef enum logic [COND_W-1:0] {
        CC_ALWAYS = 4'h0,
        CC_NE     = 4'h1,
        CC_EQ     = 4'h2,
        CC_UGT    = 4'h3,
        CC_UGE    = 4'h4,
        CC_SGT    = 4'hC,
        CC_SGE    = 4'hD
    } cond_code_e;

    typedef struct packed {
        logic taken;
        logic invalid;
    } decision_t;

endpackage

// File: rtl/brcond_operand_sel.sv
module brcond_operand_sel
    import brcond_pkg::*;
#(
    parameter int              XLEN    = 32,
    parameter logic [OPC_W-1:0] OPC_REG = 8'h40,
    parameter logic [OPC_W-1:0] OPC_IMM = 8'h41
) (
    input  logic [OPC_W-1:0] opcode,
    input  logic [IDX_W-1:0] rs1_idx,
    input  logic [IDX_W-1:0] rs2_idx,
    input  logic [IMM_W-1:0] imm,
    input  logic [XLEN-1:0]  rs1_val,
    input  logic [XLEN-1:0]  rs2_val,
    output logic [XLEN-1:0]  op_a,
    output logic [XLEN-1:0]  op_b,
    output logic             is_branch
);

    localparam int EXT_W = XLEN - IMM_W;

    typedef struct packed {
        logic [XLEN-1:0] a;
        logic [XLEN-1:0] b;
        logic            br;
    } sel_t;

    sel_t sel_d;

    always_comb begin
        sel_d    = '0;
        sel_d.a  = (rs1_idx == '0) ? '0 : rs1_val;
        if (opcode == OPC_REG) begin
            sel_d.br = 1'b1;
            sel_d.b  = (rs2_idx == '0) ? '0 : rs2_val;
        end else if (opcode == OPC_IMM) begin
            sel_d.br = 1'b1;
            sel_d.b  = {{EXT_W{imm[IMM_W-1]}}, imm};
        end
    end

    assign op_a      = sel_d.a;
    assign op_b      = sel_d.b;
    assign is_branch = sel_d.br;

    // R2: a zero index never lets a register value through
    always_comb begin
        if (rs1_idx == '0)
            a_r2_rs1_zero: assert (op_a == '0) else $error("rs1 index 0 not zero");
        if (opcode == OPC_REG && rs2_idx == '0)
            a_r2_rs2_zero: assert (op_b == '0) else $error("rs2 index 0 not zero");
        // R10: upper bits of the immediate comparand copy bit 15
        if (opcode == OPC_IMM)
            a_r10_sign_ext: assert (op_b[XLEN-1] == imm[IMM_W-1]) else $error("immediate not sign-extended");
    end

endmodule

// File: rtl/brcond_compare.sv
module brcond_compare #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic            eq,
    output logic            uge,
    output logic            sge
);

    logic sign_differs;

    always_comb begin
        eq           = (a == b);
        uge          = (a >= b);
        sign_differs = a[XLEN-1] ^ b[XLEN-1];
        // when the signs differ, unsigned and signed order are opposite
        sge          = uge ^ sign_differs;
    end

    always_comb begin
        // R4/R5/R6: equal operands satisfy both non-strict orderings
        if (eq)
            a_r6_eq_implies_ge: assert (uge && sge) else $error("equal operands not ordered ge");
        if (!sign_differs)
            a_r5_same_sign_agree: assert (uge == sge) else $error("same-sign order mismatch");
    end

endmodule

// File: rtl/brcond_decide.sv
module brcond_decide
    import brcond_pkg::*;
(
    input  logic [COND_W-1:0] cond,
    input  logic              is_branch,
    input  logic              eq,
    input  logic              uge,
    input  logic              sge,
    output decision_t         dec
);

    decision_t dec_d;

    always_comb begin
        dec_d = '0;
        if (is_branch) begin
            case (cond)
                CC_ALWAYS: dec_d.taken = 1'b1;
                CC_NE:     dec_d.taken = !eq;
                CC_EQ:     dec_d.taken = eq;
                CC_UGT:    dec_d.taken = uge && !eq;
                CC_UGE:    dec_d.taken = uge;
                CC_SGT:    dec_d.taken = sge && !eq;
                CC_SGE:    dec_d.taken = sge;
                default:   dec_d.invalid = 1'b1;
            endcase
        end
    end

    assign dec = dec_d;

endmodule

// File: rtl/brcond_unit.sv
module brcond_unit
    import brcond_pkg::*;
#(
    parameter int               XLEN    = 32,
    parameter logic [OPC_W-1:0] OPC_REG = 8'h40,
    parameter logic [OPC_W-1:0] OPC_IMM = 8'h41
) (
    input  logic [INSTR_W-1:0] instr,
    input  logic [XLEN-1:0]    ip,
    input  logic [XLEN-1:0]    rs1_val,
    input  logic [XLEN-1:0]    rs2_val,
    input  logic [XLEN-1:0]    target,
    output logic               taken,
    output logic               cond_invalid,
    output logic [XLEN-1:0]    next_ip
);

    localparam logic [XLEN-1:0] IP_STEP = XLEN'(1);

    logic [OPC_W-1:0]  opcode;
    logic [COND_W-1:0] cond;
    logic [IDX_W-1:0]  rs1_idx;
    logic [IDX_W-1:0]  rs2_idx;
    logic [IMM_W-1:0]  imm;
    logic [XLEN-1:0]   op_a;
    logic [XLEN-1:0]   op_b;
    logic              is_branch;
    logic              eq;
    logic              uge;
    logic              sge;
    decision_t         dec;
    logic [XLEN-1:0]   next_ip_d;

    // R1: field positions
    always_comb begin
        opcode  = instr[INSTR_W-1:OPC_LSB];
        cond    = instr[OPC_LSB-1:COND_LSB];
        rs1_idx = instr[COND_LSB-1:RS1_LSB];
        rs2_idx = instr[RS1_LSB-1:RS2_LSB];
        imm     = instr[IMM_W-1:0];
    end

    brcond_operand_sel #(
        .XLEN    (XLEN),
        .OPC_REG (OPC_REG),
        .OPC_IMM (OPC_IMM)
    ) u_sel (
        .opcode    (opcode),
        .rs1_idx   (rs1_idx),
        .rs2_idx   (rs2_idx),
        .imm       (imm),
        .rs1_val   (rs1_val),
        .rs2_val   (rs2_val),
        .op_a      (op_a),
        .op_b      (op_b),
        .is_branch (is_branch)
    );

    brcond_compare #(
        .XLEN (XLEN)
    ) u_cmp (
        .a   (op_a),
        .b   (op_b),
        .eq  (eq),
        .uge (uge),
        .sge (sge)
    );

    brcond_decide u_dec (
        .cond      (cond),
        .is_branch (is_branch),
        .eq        (eq),
        .uge       (uge),
        .sge       (sge),
        .dec       (dec)
    );

    always_comb begin
        next_ip_d = dec.taken ? target : (ip + IP_STEP);
    end

    assign taken        = dec.taken;
    assign cond_invalid = dec.invalid;
    assign next_ip      = next_ip_d;

    always_comb begin
        // R7: an undefined code never jumps
        if (cond_invalid)
            a_r7_invalid_not_taken: assert (!taken) else $error("invalid code taken");
        // R3: code 0 on a branch opcode always jumps
        if ((opcode == OPC_REG || opcode == OPC_IMM) && cond == 4'h0)
            a_r3_always_taken: assert (taken) else $error("code 0 not taken");
        // R9: foreign opcodes are inert
        if (opcode != OPC_REG && opcode != OPC_IMM)
            a_r9_foreign_inert: assert (!taken && !cond_invalid) else $error("foreign opcode acted");
        // R8: fall-through advances by one
        if (!taken)
            a_r8_fallthrough: assert (next_ip == ip + IP_STEP) else $error("fall-through ip wrong");
    end

endmodule

// File: tb/brcond_unit_bench.sv
module brcond_unit_bench;

    localparam logic [7:0] OREG = 8'h40;
    localparam logic [7:0] OIMM = 8'h41;

    logic        clk = 1'b0;
    logic [31:0] instr, ip, rs1_val, rs2_val, target;
    logic        taken, cond_invalid;
    logic [31:0] next_ip;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    always #4 clk = ~clk; // 125 MHz

    brcond_unit u_brcond_unit (
        .instr        (instr),
        .ip           (ip),
        .rs1_val      (rs1_val),
        .rs2_val      (rs2_val),
        .target       (target),
        .taken        (taken),
        .cond_invalid (cond_invalid),
        .next_ip      (next_ip)
    );

    function automatic logic [1:0] model(input logic [31:0] ins,
                                         input logic [31:0] v1,
                                         input logic [31:0] v2);
        logic [31:0] a, b;
        logic t, inv;
        t = 0; inv = 0;
        a = (ins[19:16] == 0) ? 32'h0 : v1;
        if (ins[31:24] == OREG)      b = (ins[15:12] == 0) ? 32'h0 : v2;
        else if (ins[31:24] == OIMM) b = {{16{ins[15]}}, ins[15:0]};
        else return 2'b00;
        case (ins[23:20])
            4'h0: t = 1;
            4'h1: t = (a != b);
            4'h2: t = (a == b);
            4'h3: t = (a > b);
            4'h4: t = (a >= b);
            4'hC: t = ($signed(a) > $signed(b));
            4'hD: t = ($signed(a) >= $signed(b));
            default: inv = 1;
        endcase
        return {t, inv};
    endfunction

    function automatic string tag_of(input logic [31:0] ins);
        if (ins[31:24] != OREG && ins[31:24] != OIMM) return "R9";
        case (ins[23:20])
            4'h0: return "R3";
            4'h1, 4'h2: return "R4";
            4'h3, 4'h4: return (ins[31:24] == OIMM) ? "R10" : "R5";
            4'hC, 4'hD: return (ins[31:24] == OIMM) ? "R10" : "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h (instr %h)", req, what, act, exp, instr);
        end
    endtask

    task automatic apply(input logic [31:0] ins, input logic [31:0] v1,
                         input logic [31:0] v2, input logic [31:0] p,
                         input logic [31:0] tg, input string req);
        logic [1:0]  e;
        logic [31:0] enip;
        @(posedge clk);
        instr = ins; rs1_val = v1; rs2_val = v2; ip = p; target = tg;
        @(negedge clk);
        e    = model(ins, v1, v2);
        enip = e[1] ? tg : p + 32'd1;
        check(req, "taken", {31'd0, taken}, {31'd0, e[1]});
        check(req, "cond_invalid", {31'd0, cond_invalid}, {31'd0, e[0]});
        check("R8", "next_ip", next_ip, enip);
    endtask

    function automatic logic [31:0] mk(input logic [7:0] opc, input logic [3:0] cc,
                                       input logic [3:0] r1, input logic [15:0] low);
        return {opc, cc, r1, low};
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fails++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin : stim
        void'($urandom(32'd1234));
        instr = 0; ip = 0; rs1_val = 0; rs2_val = 0; target = 0;
        // idle word: foreign opcode, pointer advances (R9)
        apply(32'h0, 32'h0, 32'h0, 32'h10, 32'h99, "R9");
        // R1 register form, R4 equality
        apply(mk(OREG, 4'h2, 4'h3, 16'h5000), 32'h1234, 32'h1234, 32'h20, 32'h80, "R1");
        // R2: rs1 index 0 reads zero though value is non-zero
        apply(mk(OREG, 4'h2, 4'h0, 16'h0000), 32'hDEAD, 32'hBEEF, 32'h30, 32'h40, "R2");
        apply(mk(OREG, 4'h1, 4'h0, 16'h0000), 32'hDEAD, 32'hBEEF, 32'h30, 32'h40, "R2");
        // R3 always
        apply(mk(OIMM, 4'h0, 4'h5, 16'h0001), 32'h0, 32'h0, 32'h50, 32'h1000, "R3");
        // R5/R6 across the sign boundary
        apply(mk(OREG, 4'h3, 4'h1, 16'h2000), 32'h8000_0000, 32'h1, 32'h0, 32'h7, "R5");
        apply(mk(OREG, 4'hC, 4'h1, 16'h2000), 32'h8000_0000, 32'h1, 32'h0, 32'h7, "R6");
        apply(mk(OREG, 4'h4, 4'h1, 16'h2000), 32'h0, 32'hFFFF_FFFF, 32'h0, 32'h7, "R5");
        apply(mk(OREG, 4'hD, 4'h1, 16'h2000), 32'h0, 32'hFFFF_FFFF, 32'h0, 32'h7, "R6");
        // equal operands under strict and non-strict codes
        apply(mk(OREG, 4'h3, 4'h1, 16'h2000), 32'h55, 32'h55, 32'h0, 32'h7, "R5");
        apply(mk(OREG, 4'hD, 4'h1, 16'h2000), 32'h55, 32'h55, 32'h0, 32'h7, "R6");
        // R10: immediate 16'hFFFF equals register -1
        apply(mk(OIMM, 4'h2, 4'h4, 16'hFFFF), 32'hFFFF_FFFF, 32'h0, 32'h8, 32'h60, "R10");
        apply(mk(OIMM, 4'hC, 4'h4, 16'h8000), 32'h0, 32'h0, 32'h8, 32'h60, "R10");
        // R7 invalid code, R8 wrap of ip
        apply(mk(OREG, 4'h7, 4'h1, 16'h1000), 32'h1, 32'h1, 32'hFFFF_FFFF, 32'h60, "R7");
        apply(mk(OIMM, 4'hF, 4'h1, 16'h1000), 32'h1, 32'h1, 32'h4, 32'h60, "R7");
        // random mix
        for (int i = 0; i < 3000; i++) begin
            logic [7:0]  opc;
            logic [31:0] ins, v1, v2;
            int          pick;
            pick = $urandom_range(0, 9);
            opc  = (pick < 5) ? OREG : (pick < 9) ? OIMM : 8'($urandom);
            ins  = {opc, 24'($urandom)};
            v1   = $urandom;
            v2   = $urandom;
            case ($urandom_range(0, 3))
                0: v2 = v1;
                1: v1 = {{16{ins[15]}}, ins[15:0]};
                2: begin v1 = {v1[31], 31'd3}; v2 = {~v1[31], 31'd3}; end
                default: ;
            endcase
            apply(ins, v1, v2, $urandom, $urandom, tag_of(ins));
        end
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule